// File: doc/BRIEF.md
# ADPLL Phase-Frequency Loop Controller

This block is the digital loop controller of an all-digital PLL. All of its logic runs on one system clock. A one-cycle enable, `oscTick`, marks each oscillator period that the block must count. Single-cycle pulses, `refEdge` and `fbEdge`, mark the rising edges of the reference clock and of the divided feedback clock. From these the block measures two quantities, both in oscillator cycles:

- the phase offset of the feedback edge behind the reference edge;
- the length of each reference period.

Phase offset is removed by shortening the feedback divider's divisor for a single feedback period. Frequency error is removed by stepping the oscillator control word.

After a `start` pulse, the controller moves through a fixed sequence:

1. It waits for a reference edge to align to.
2. It spends one reference period correcting phase only.
3. It enters acquisition, where every reference period applies both a phase correction and a gain-scaled coarse code step.
4. Once the loop has been inside a narrow error window for several periods in a row, it raises `lock` and switches to tracking. In tracking, five fractional bits extend the control word and move by one step per period.

Top module: `adpll_loop_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `ctrlCode` = {coarse[10:0], frac[4:0]} reads coarse 1024 and frac 0, i.e. 32768. At the same time `divisor` equals the nominal divisor N and `lock` is 0.
- R2: Until a `start` pulse arrives, reference and feedback edges change neither `ctrlCode` nor `divisor`.
- R3: A measured count is the number of cycles with `oscTick` high in the interval after one edge, up to and including the closing edge. For a reference period, that interval runs from the previous reference edge to the current one. For the phase error, it runs from a reference edge to the next feedback edge.
- R4: After `start`, the first reference edge only aligns the controller. The second reference edge ends the phase-only period and leaves `ctrlCode` unchanged.
- R5: Once aligned, a feedback edge that follows a reference edge, with no feedback edge in between, sets `divisor` to N minus the phase error from the next cycle. If the phase error is N or more, `divisor` is set to 1 instead.
- R6: A feedback edge with no reference edge since the previous feedback edge returns `divisor` to N. `divisor` changes only in the cycle after a feedback edge.
- R7: In acquisition, each reference edge adds (N − measured period) shifted left by `gainShift` to the coarse code, with frac held at 0. `ctrlCode` changes only in the cycle after a reference edge.
- R8: The coarse code saturates at 0 and at 2047 during acquisition.
- R9: At a reference edge in acquisition, the loop counts as in range when the measured period is within N ± 1 and the latest phase error is at most 1. When four reference edges in a row are in range, `lock` rises on the next cycle. An out-of-range edge restarts the count. Once high, `lock` stays high until reset.
- R10: In tracking, each reference edge moves the whole 16-bit `ctrlCode` by +1 when the measured period is shorter than N, by −1 when it is longer, and leaves it unchanged when it equals N. The word saturates at 0 and at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that begins a lock sequence from idle |
| oscTick | input | 1 | High in cycles that hold one oscillator period |
| refEdge | input | 1 | Reference clock rising-edge pulse |
| fbEdge | input | 1 | Divided feedback clock rising-edge pulse |
| gainShift | input | 2 | Left shift applied to the frequency error in acquisition |
| divisor | output | 12 | Feedback divider divisor for the current feedback period |
| ctrlCode | output | 16 | Oscillator control word: coarse code above five fractional bits |
| lock | output | 1 | High once tracking mode is reached |

## Verification
The bench drives whole reference periods. Each period has a chosen length, a chosen feedback-edge offset, an optional second feedback edge and an optional run of idle oscillator cycles. Expected values come from an arithmetic model of the stated update rules.

The stimulus falls into groups, each with a purpose:

- Periods above, at and below N, at several gain shifts, separate sign and scaling errors in the code step.
- Idle-tick periods show whether counts follow `oscTick` rather than the system clock.
- A phase error larger than N probes the divisor floor.
- A second feedback edge shows whether the correction lasts exactly one feedback period.
- Long runs of very short and very long periods drive the coarse code into both rails.
- A broken run of in-range periods, followed by tracking steps that hit zero, separates correct run counting and fractional stepping from off-by-one and wrap faults.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Sequencer states of the loop controller
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_PHASE,
    ST_ACQ,
    ST_TRACK
  } pfcState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic freqUpd;   // coarse code update at this reference edge
    logic fracUpd;   // fine (tracking) update at this reference edge
    logic phaseEn;   // feedback edges may retune the divisor
  } pfcStrobe_t;

endpackage

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int COARSE_W = 11,
  parameter int FRAC_W   = 5,
  parameter int GAIN_W   = 2,
  parameter int NOM_DIV  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       oscTick,
  input  logic                       refEdge,
  input  logic                       fbEdge,
  input  logic [GAIN_W-1:0]          gainShift,
  input  pfcStrobe_t                 stb,
  output logic [CNT_W-1:0]           divisor,
  output logic [COARSE_W+FRAC_W-1:0] ctrlCode,
  output logic                       errSmall
);

  localparam int CODE_W = COARSE_W + FRAC_W;
  localparam int ERR_W  = CNT_W + 2;
  localparam int SUM_W  = ERR_W + (1 << GAIN_W) + COARSE_W;
  localparam logic [CNT_W-1:0]    CNT_MAX = '1;
  localparam logic [CNT_W-1:0]    NOM     = CNT_W'(NOM_DIV);
  localparam logic [COARSE_W-1:0] MID     = {1'b1, {(COARSE_W-1){1'b0}}};
  localparam logic [COARSE_W-1:0] CMAX    = '1;

  logic [CNT_W-1:0]        sinceRef;
  logic [CNT_W-1:0]        cntNow;
  logic [CNT_W-1:0]        phaseErr;
  logic                    armed;
  logic [COARSE_W-1:0]     coarse;
  logic [FRAC_W-1:0]       frac;
  logic signed [ERR_W-1:0] freqErr;
  logic signed [SUM_W-1:0] deltaCode;
  logic signed [SUM_W-1:0] coarseSum;
  logic [COARSE_W-1:0]     coarseNext;
  logic [CODE_W-1:0]       codeNow;
  logic [CODE_W-1:0]       trackNext;
  logic [CNT_W-1:0]        corrDiv;

  // Oscillator cycles since the last reference edge, including this cycle
  always_comb begin
    if (oscTick && sinceRef != CNT_MAX) cntNow = sinceRef + 1'b1;
    else                                cntNow = sinceRef;
  end

  // Signed frequency error: positive means too few oscillator cycles
  always_comb begin
    freqErr   = $signed({2'b00, NOM}) - $signed({2'b00, cntNow});
    deltaCode = SUM_W'(freqErr) <<< gainShift;
    coarseSum = $signed({{(SUM_W-COARSE_W){1'b0}}, coarse}) + deltaCode;
    if (coarseSum[SUM_W-1])
      coarseNext = '0;
    else if (coarseSum > $signed({{(SUM_W-COARSE_W){1'b0}}, CMAX}))
      coarseNext = CMAX;
    else
      coarseNext = coarseSum[COARSE_W-1:0];
  end

  // Tracking: whole word steps by one, saturating at both rails
  always_comb begin
    codeNow = {coarse, frac};
    if (!freqErr[ERR_W-1] && freqErr != '0 && codeNow != '1)
      trackNext = codeNow + 1'b1;
    else if (freqErr[ERR_W-1] && codeNow != '0)
      trackNext = codeNow - 1'b1;
    else
      trackNext = codeNow;
  end

  // One-period divisor that cancels the measured feedback lag
  always_comb begin
    if (cntNow >= NOM) corrDiv = CNT_W'(1);
    else               corrDiv = NOM - cntNow;
  end

  always_comb begin
    errSmall = ((freqErr == '0) || (freqErr == ERR_W'(1)) || (freqErr == '1))
               && (phaseErr <= CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRef <= '0;
      armed    <= 1'b0;
      phaseErr <= '0;
      divisor  <= NOM;
      coarse   <= MID;
      frac     <= '0;
    end else begin
      sinceRef <= refEdge ? '0 : cntNow;
      if (fbEdge)       armed <= 1'b0;
      else if (refEdge) armed <= 1'b1;
      if (fbEdge && refEdge)    phaseErr <= '0;
      else if (fbEdge && armed) phaseErr <= cntNow;
      if (stb.phaseEn && fbEdge)
        divisor <= (armed && !refEdge) ? corrDiv : NOM;
      if (stb.freqUpd)
        coarse <= coarseNext;
      else if (stb.fracUpd)
        {coarse, frac} <= trackNext;
    end
  end

  assign ctrlCode = {coarse, frac};

  // R5
  divisor_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    divisor != '0);

  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fbEdge |=> $stable(divisor));

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !refEdge |=> $stable(ctrlCode));

  // R10
  track_step_chk: assert property (@(posedge clk) disable iff (rst)
    stb.fracUpd |=> (ctrlCode == $past(ctrlCode))
                 || (ctrlCode == $past(ctrlCode) + 1'b1)
                 || (ctrlCode == $past(ctrlCode) - 1'b1));

endmodule

// File: rtl/pfc_control.sv
module pfc_control
  import pfc_pkg::*;
#(
  parameter int LOCK_RUNS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       refEdge,
  input  logic       errSmall,
  output pfcStrobe_t stb,
  output logic       lock
);

  localparam int GW = $clog2(LOCK_RUNS + 1);
  localparam logic [GW-1:0] LAST = GW'(LOCK_RUNS - 1);

  pfcState_t     state;
  logic [GW-1:0] goodCnt;

  always_comb begin
    stb.freqUpd = refEdge && (state == ST_ACQ);
    stb.fracUpd = refEdge && (state == ST_TRACK);
    stb.phaseEn = (state == ST_PHASE) || (state == ST_ACQ) || (state == ST_TRACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      goodCnt <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_ALIGN;
        ST_ALIGN: if (refEdge) state <= ST_PHASE;
        ST_PHASE: if (refEdge) state <= ST_ACQ;
        ST_ACQ: begin
          if (refEdge) begin
            if (!errSmall) begin
              goodCnt <= '0;
            end else if (goodCnt == LAST) begin
              goodCnt <= '0;
              state   <= ST_TRACK;
            end else begin
              goodCnt <= goodCnt + 1'b1;
            end
          end
        end
        ST_TRACK: state <= ST_TRACK;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign lock = (state == ST_TRACK);

  // R2
  idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> state == ST_IDLE);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);

  // R9
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(state) == ST_ACQ);

endmodule

// File: rtl/adpll_loop_ctrl.sv
module adpll_loop_ctrl
  import pfc_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int COARSE_W  = 11,
  parameter int FRAC_W    = 5,
  parameter int GAIN_W    = 2,
  parameter int NOM_DIV   = 64,
  parameter int LOCK_RUNS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       oscTick,
  input  logic                       refEdge,
  input  logic                       fbEdge,
  input  logic [GAIN_W-1:0]          gainShift,
  output logic [CNT_W-1:0]           divisor,
  output logic [COARSE_W+FRAC_W-1:0] ctrlCode,
  output logic                       lock
);

  pfcStrobe_t stb;
  logic       errSmall;

  pfc_control #(.LOCK_RUNS(LOCK_RUNS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .refEdge(refEdge),
    .errSmall(errSmall), .stb(stb), .lock(lock)
  );

  pfc_datapath #(
    .CNT_W(CNT_W), .COARSE_W(COARSE_W), .FRAC_W(FRAC_W),
    .GAIN_W(GAIN_W), .NOM_DIV(NOM_DIV)
  ) u_dp (
    .clk(clk), .rst(rst), .oscTick(oscTick), .refEdge(refEdge),
    .fbEdge(fbEdge), .gainShift(gainShift), .stb(stb),
    .divisor(divisor), .ctrlCode(ctrlCode), .errSmall(errSmall)
  );

endmodule

// File: tb/adpll_loop_ctrl_tb.sv
`timescale 1ns/1ps
module adpll_loop_ctrl_tb;

  localparam int NOM   = 16;
  localparam int LOCKR = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        oscTick = 1'b1;
  logic        refEdge = 1'b0;
  logic        fbEdge = 1'b0;
  logic [1:0]  gainShift = 2'd0;
  logic [11:0] divisor;
  logic [15:0] ctrlCode;
  logic        lock;

  int nChecks = 0;
  int nFail = 0;

  // bench model of the expected state
  int mSt = 0;        // 0 idle, 1 align, 2 phase-only, 3 acquire, 4 track
  int mCode = 32768;
  int mGood = 0;
  int mPrevLen = 0;
  int mPrevPh = 0;
  int mDiv = NOM;

  always #2.5 clk = ~clk;

  adpll_loop_ctrl #(.NOM_DIV(NOM), .LOCK_RUNS(LOCKR)) u_dut (
    .clk(clk), .rst(rst), .start(start), .oscTick(oscTick),
    .refEdge(refEdge), .fbEdge(fbEdge), .gainShift(gainShift),
    .divisor(divisor), .ctrlCode(ctrlCode), .lock(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelRef(input int g);
    int fe, c;
    fe = NOM - mPrevLen;
    case (mSt)
      1: mSt = 2;
      2: mSt = 3;
      3: begin
        c = (mCode / 32) + fe * (1 << g);
        if (c < 0) c = 0;
        if (c > 2047) c = 2047;
        mCode = c * 32;
        if (fe >= -1 && fe <= 1 && mPrevPh <= 1) begin
          if (mGood == LOCKR - 1) begin mGood = 0; mSt = 4; end
          else mGood++;
        end else mGood = 0;
      end
      4: begin
        if (fe > 0 && mCode < 65535) mCode++;
        else if (fe < 0 && mCode > 0) mCode--;
      end
      default: ;
    endcase
  endtask

  // one reference period: len cycles, feedback at fbAt, optional second
  // feedback at fb2, oscTick low at offsets 1..gap
  task automatic runPeriod(input int len, input int fbAt, input int fb2,
                           input int gap, input int g,
                           input string tagC, input string tagD);
    int ph;
    for (int off = 0; off < len; off++) begin
      @(negedge clk);
      if (off == 1) begin
        chk(tagC, int'(ctrlCode), mCode);
        chk("R9", int'(lock), (mSt == 4) ? 1 : 0);
      end
      if (off == fbAt + 1) chk(tagD, int'(divisor), mDiv);
      if (fb2 != 0 && off == fb2 + 1) chk("R6", int'(divisor), mDiv);
      refEdge   = (off == 0);
      fbEdge    = (off == fbAt) || (fb2 != 0 && off == fb2);
      oscTick   = !(off >= 1 && off <= gap);
      gainShift = 2'(g);
      if (off == 0) modelRef(g);
      if (off == fbAt) begin
        ph = fbAt - gap;
        mPrevPh = ph;
        if (mSt >= 2) mDiv = (ph >= NOM) ? 1 : NOM - ph;
      end
      if (fb2 != 0 && off == fb2 && mSt >= 2) mDiv = NOM;
    end
    mPrevLen = len - gap;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL R1 watchdog expired actual 0 expected 1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(ctrlCode), 32768);
    chk("R1", int'(divisor), NOM);
    chk("R1", int'(lock), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(ctrlCode), 32768);
    chk("R1", int'(divisor), NOM);
    chk("R1", int'(lock), 0);

    // R2: edges before start are ignored
    runPeriod(16, 5, 0, 0, 1, "R2", "R2");
    runPeriod(20, 3, 0, 0, 1, "R2", "R2");

    @(negedge clk); start = 1'b1; refEdge = 1'b0; fbEdge = 1'b0;
    @(negedge clk); start = 1'b0;
    mSt = 1;

    // R4: align, then a phase-only period
    runPeriod(16, 5, 0, 0, 1, "R4", "R5");
    runPeriod(20, 3, 0, 0, 1, "R4", "R5");
    // R7: acquisition steps with different gains and signs
    runPeriod(12, 2, 0, 0, 1, "R7", "R5");
    runPeriod(16, 4, 0, 0, 2, "R7", "R5");
    runPeriod(16, 6, 10, 0, 0, "R7", "R5");
    // R3: idle oscillator cycles excluded from both counts
    runPeriod(18, 7, 0, 3, 0, "R7", "R3");
    runPeriod(16, 3, 0, 0, 1, "R3", "R5");
    // R5: phase error beyond N gives divisor 1
    runPeriod(40, 20, 0, 0, 0, "R7", "R5");
    runPeriod(16, 2, 0, 0, 0, "R7", "R5");
    // R8: drive to the upper rail, then to the lower rail
    for (int i = 0; i < 25; i++) runPeriod(4, 2, 0, 0, 3, "R8", "R5");
    chk("R8", int'(ctrlCode), 2047 * 32);
    for (int i = 0; i < 10; i++) runPeriod(60, 2, 0, 0, 3, "R8", "R5");
    chk("R8", int'(ctrlCode), 0);
    // R9: three in range, one broken, then four in range
    for (int i = 0; i < 3; i++) runPeriod(16, 1, 0, 0, 2, "R9", "R5");
    runPeriod(16, 5, 0, 0, 2, "R9", "R5");
    for (int i = 0; i < 5; i++) runPeriod(16, 1, 0, 0, 2, "R9", "R5");
    chk("R9", int'(lock), 1);
    // R10: fractional steps up, down, hold and lower saturation
    runPeriod(15, 1, 0, 0, 2, "R10", "R5");
    runPeriod(15, 1, 0, 0, 2, "R10", "R5");
    runPeriod(17, 1, 0, 0, 2, "R10", "R5");
    runPeriod(17, 1, 0, 0, 2, "R10", "R5");
    runPeriod(17, 1, 0, 0, 2, "R10", "R5");
    runPeriod(16, 1, 0, 0, 2, "R10", "R5");
    runPeriod(16, 1, 0, 0, 2, "R10", "R5");
    @(negedge clk);
    refEdge = 1'b0;
    fbEdge = 1'b0;
    chk("R10", int'(ctrlCode), mCode);
    chk("R9", int'(lock), 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule